// File: doc/BRIEF.md
# Backplane RoI Frame Packer

The block gathers one bunch crossing's worth of summary data from a jet processing module and spreads it over a wide bank of backplane lines that run at four times the crossing rate. The summary holds eight region-of-interest entries and three energy sums. Each entry has a 2-bit location and 8 threshold-hit flags, and the sums are the scalar total and the two vector components at 12 bits each. That is 116 payload bits per 25 ns crossing. The block runs on the fast (4x) line clock. Each crossing is one frame of four consecutive cycles on a 50-line bus, which gives 200 bit-slots. A frame strobe marks the first cycle of every frame.

The record enters through a valid/ready handshake. `in_ready` is high only in the last cycle of each frame. The record is taken into a holding register on that edge, and only if `in_valid` is high then; it is sent during the four cycles that follow. `in_valid` has no effect in any other cycle. If no valid record is offered at the capture point, the next frame carries all zeros. The backplane can never stall, so there is no back-pressure on the output side, and the checking outputs only pulse a valid flag.

A compression mode is chosen per frame by `scale_en`, which is sampled at the capture edge. In that mode each sum is reduced to an 8-bit code before packing. A companion unpacker watches the bus, rebuilds the record from each complete frame and presents it one frame later, so that the link can be checked end to end.

Top module: `roi_frame_packer`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `bp_frame` is 1, `bp_data` is all zero and `chk_valid` is 0. The frame sent straight after reset is all zeros.
- R2: `bp_frame` is high in exactly one cycle of every four. That cycle carries slot 0 of a frame.
- R3: `in_ready` is high only in slot 3 (the last cycle) of each frame. The record is captured only on the rising edge that ends that cycle, and it is sent in the four cycles that follow.
- R4: If `in_valid` is low in the `in_ready` cycle, every line is 0 in all four slots of the next frame.
- R5: Payload bit k of a frame is driven on line (k mod 50) in slot (k div 50). RoI entry i fills bits 10i to 10i+9: location bit 0, then location bit 1, then threshold bits 0 to 7. Entry i takes location bits 2i+1:2i of `in_loc` and threshold bits 8i+7:8i of `in_thr`.
- R6: With scaling off, the scalar sum fills bits 80 to 91, the first component fills bits 92 to 103 and the second component fills bits 104 to 115, each least significant bit first.
- R7: Payload bits 116 to 199 are always 0. These are lines 16 to 49 of slot 2 and all lines of slot 3.
- R8: With scaling on, each 12-bit sum field carries the sum shifted right by 4 in its low 8 bits, and its upper 4 bits are 0. For example, 0xFFF gives 0x0FF, 0x00F gives 0 and 0x7F0 gives 0x07F.
- R9: Input changes in slots 0 to 2 have no effect on the frame in flight.
- R10: `chk_valid` is high for one cycle, in slot 0 of a frame, and is low in every other cycle. In that cycle the `chk_*` outputs hold the fields sent in the previous frame: the location and threshold bits, and the three 12-bit sum fields exactly as they were sent.
- R11: `scale_en` is sampled only at the capture edge. Changing it during a frame does not change the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock, four cycles per crossing |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Record on the inputs is valid |
| in_ready | output | 1 | Capture point; high in the last slot of a frame |
| scale_en | input | 1 | Compress the sums to 8-bit codes for this record |
| in_loc | input | 16 | Location bits, 2 per RoI entry |
| in_thr | input | 64 | Threshold-hit flags, 8 per RoI entry |
| in_et | input | 12 | Scalar energy sum |
| in_ex | input | 12 | First vector component |
| in_ey | input | 12 | Second vector component |
| bp_data | output | 50 | Backplane lines |
| bp_frame | output | 1 | Frame strobe, high in slot 0 |
| chk_valid | output | 1 | Rebuilt record is present |
| chk_loc | output | 16 | Rebuilt location bits |
| chk_thr | output | 64 | Rebuilt threshold flags |
| chk_et | output | 12 | Rebuilt scalar sum field |
| chk_ex | output | 12 | Rebuilt first component field |
| chk_ey | output | 12 | Rebuilt second component field |

## Verification
The bench scrambles every input, including the scale mode and the valid flag, in the middle of each frame. A design that sampled the inputs live instead of through the holding register would then send a torn frame, with slots from two different records. Directed frames drive all ones with scaling on and off, sum values sitting just under and just over a code step, and frames with no valid record. A wrong shift or a missing mask in the scaler would leak upper bits into the code, and a stale holding register would repeat the last record when it should send zeros. Each slot is compared with a bit stream that the bench builds from its own field map, so a line offset or an entry order that is off by one shows up at once. The rebuilt record is checked one frame later to catch an unpacker that is off by one slot.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
  localparam int RFP_N_ROI      = 8;
  localparam int RFP_LOC_W      = 2;
  localparam int RFP_THR_W      = 8;
  localparam int RFP_SUM_W      = 12;
  localparam int RFP_CODE_W     = 8;
  localparam int RFP_SHIFT      = 4;
  localparam int RFP_LINES      = 50;
  localparam int RFP_MUX        = 4;
  localparam int RFP_N_SUM      = 3;

  typedef enum logic [1:0] {
    SUM_ET = 2'd0,
    SUM_EX = 2'd1,
    SUM_EY = 2'd2
  } sum_sel_e;
endpackage

// File: rtl/rfp_scaler.sv
module rfp_scaler #(
  parameter int SUM_W  = 12,
  parameter int CODE_W = 8,
  parameter int SHIFT  = 4
) (
  input  logic             scale_en,
  input  logic [SUM_W-1:0] sum_in,
  output logic [SUM_W-1:0] field_out
);
  localparam int HI_W = SUM_W - CODE_W - SHIFT;

  logic [CODE_W-1:0] code;

  generate
    if (HI_W > 0) begin : g_sat
      logic over;
      assign over = |sum_in[SUM_W-1 -: HI_W];
      assign code = over ? {CODE_W{1'b1}} : sum_in[SHIFT +: CODE_W];
    end else begin : g_plain
      assign code = sum_in[SHIFT +: CODE_W];
    end
  endgenerate

  assign field_out = scale_en ? {{(SUM_W-CODE_W){1'b0}}, code} : sum_in;
endmodule

// File: rtl/rfp_framer.sv
module rfp_framer #(
  parameter int PAY_W = 116,
  parameter int LINES = 50,
  parameter int MUX   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] payload,
  output logic [LINES-1:0] bp_data,
  output logic             bp_frame
);
  localparam int SLOT_BITS = LINES * MUX;
  localparam int CNT_W     = (MUX > 1) ? $clog2(MUX) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MUX - 1);

  logic [CNT_W-1:0]     cnt;
  logic [PAY_W-1:0]     hold;
  logic [SLOT_BITS-1:0] stream;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      hold <= '0;
    end else begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      if (cnt == LAST) begin
        hold <= in_valid ? payload : '0;
      end
    end
  end

  assign in_ready = (cnt == LAST);
  assign bp_frame = (cnt == '0);
  assign stream   = {{(SLOT_BITS-PAY_W){1'b0}}, hold};
  assign bp_data  = stream[int'(cnt)*LINES +: LINES];

  a_r2_frame_gap: assert property (@(posedge clk) disable iff (!rst_n)
    bp_frame |=> !bp_frame);
  a_r3_ready_then_frame: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> bp_frame);
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(hold));
  a_r4_empty_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> (bp_data == '0));
endmodule

// File: rtl/rfp_unpacker.sv
module rfp_unpacker #(
  parameter int PAY_W = 116,
  parameter int LINES = 50,
  parameter int MUX   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] bp_data,
  input  logic             bp_frame,
  output logic             chk_valid,
  output logic [PAY_W-1:0] chk_payload
);
  localparam int SLOT_BITS = LINES * MUX;
  localparam int CNT_W     = (MUX > 1) ? $clog2(MUX) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MUX - 1);

  logic [LINES-1:0]     wbuf [MUX-1];
  logic [CNT_W-1:0]     idx;
  logic                 seen;
  logic [SLOT_BITS-1:0] full;
  logic                 pad_nz;
  logic                 at_last;

  always_comb begin
    for (int w = 0; w < MUX - 1; w++) begin
      full[w*LINES +: LINES] = wbuf[w];
    end
    full[(MUX-1)*LINES +: LINES] = bp_data;
  end

  assign pad_nz  = |full[SLOT_BITS-1:PAY_W];
  assign at_last = seen && !bp_frame && (idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx         <= '0;
      seen        <= 1'b0;
      chk_valid   <= 1'b0;
      chk_payload <= '0;
      for (int w = 0; w < MUX - 1; w++) wbuf[w] <= '0;
    end else begin
      chk_valid <= 1'b0;
      if (bp_frame) begin
        wbuf[0] <= bp_data;
        idx     <= CNT_W'(1);
        seen    <= 1'b1;
      end else if (seen) begin
        if (idx == LAST) begin
          chk_payload <= full[PAY_W-1:0];
          chk_valid   <= 1'b1;
        end else begin
          wbuf[idx] <= bp_data;
          idx       <= idx + 1'b1;
        end
      end
    end
  end

  a_r7_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    at_last |-> !pad_nz);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> !chk_valid);
endmodule

// File: rtl/roi_frame_packer.sv
module roi_frame_packer #(
  parameter int N_ROI  = rfp_pkg::RFP_N_ROI,
  parameter int LOC_W  = rfp_pkg::RFP_LOC_W,
  parameter int THR_W  = rfp_pkg::RFP_THR_W,
  parameter int SUM_W  = rfp_pkg::RFP_SUM_W,
  parameter int CODE_W = rfp_pkg::RFP_CODE_W,
  parameter int SHIFT  = rfp_pkg::RFP_SHIFT,
  parameter int LINES  = rfp_pkg::RFP_LINES,
  parameter int MUX    = rfp_pkg::RFP_MUX
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   scale_en,
  input  logic [N_ROI*LOC_W-1:0] in_loc,
  input  logic [N_ROI*THR_W-1:0] in_thr,
  input  logic [SUM_W-1:0]       in_et,
  input  logic [SUM_W-1:0]       in_ex,
  input  logic [SUM_W-1:0]       in_ey,
  output logic [LINES-1:0]       bp_data,
  output logic                   bp_frame,
  output logic                   chk_valid,
  output logic [N_ROI*LOC_W-1:0] chk_loc,
  output logic [N_ROI*THR_W-1:0] chk_thr,
  output logic [SUM_W-1:0]       chk_et,
  output logic [SUM_W-1:0]       chk_ex,
  output logic [SUM_W-1:0]       chk_ey
);
  import rfp_pkg::*;

  localparam int N_SUM    = RFP_N_SUM;
  localparam int ENTRY_W  = LOC_W + THR_W;
  localparam int ROI_BITS = N_ROI * ENTRY_W;
  localparam int PAY_W    = ROI_BITS + N_SUM * SUM_W;

  logic [SUM_W-1:0] raw_sum   [N_SUM];
  logic [SUM_W-1:0] field_sum [N_SUM];
  logic [SUM_W-1:0] back_sum  [N_SUM];
  logic [PAY_W-1:0] payload;
  logic [PAY_W-1:0] chk_payload;

  assign raw_sum[SUM_ET] = in_et;
  assign raw_sum[SUM_EX] = in_ex;
  assign raw_sum[SUM_EY] = in_ey;

  genvar gi;
  generate
    for (gi = 0; gi < N_ROI; gi++) begin : g_roi
      assign payload[gi*ENTRY_W +: LOC_W]         = in_loc[gi*LOC_W +: LOC_W];
      assign payload[gi*ENTRY_W + LOC_W +: THR_W] = in_thr[gi*THR_W +: THR_W];
      assign chk_loc[gi*LOC_W +: LOC_W] = chk_payload[gi*ENTRY_W +: LOC_W];
      assign chk_thr[gi*THR_W +: THR_W] = chk_payload[gi*ENTRY_W + LOC_W +: THR_W];
    end
    for (gi = 0; gi < N_SUM; gi++) begin : g_sum
      rfp_scaler #(
        .SUM_W (SUM_W),
        .CODE_W(CODE_W),
        .SHIFT (SHIFT)
      ) u_scale (
        .scale_en (scale_en),
        .sum_in   (raw_sum[gi]),
        .field_out(field_sum[gi])
      );
      assign payload[ROI_BITS + gi*SUM_W +: SUM_W] = field_sum[gi];
      assign back_sum[gi] = chk_payload[ROI_BITS + gi*SUM_W +: SUM_W];
    end
  endgenerate

  assign chk_et = back_sum[SUM_ET];
  assign chk_ex = back_sum[SUM_EX];
  assign chk_ey = back_sum[SUM_EY];

  rfp_framer #(
    .PAY_W(PAY_W),
    .LINES(LINES),
    .MUX  (MUX)
  ) u_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .payload (payload),
    .bp_data (bp_data),
    .bp_frame(bp_frame)
  );

  rfp_unpacker #(
    .PAY_W(PAY_W),
    .LINES(LINES),
    .MUX  (MUX)
  ) u_unpack (
    .clk        (clk),
    .rst_n      (rst_n),
    .bp_data    (bp_data),
    .bp_frame   (bp_frame),
    .chk_valid  (chk_valid),
    .chk_payload(chk_payload)
  );

  a_r10_on_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> bp_frame);
endmodule

// File: tb/tb_roi_frame_packer.sv
module tb_roi_frame_packer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic        scale_en;
  logic [15:0] in_loc;
  logic [63:0] in_thr;
  logic [11:0] in_et, in_ex, in_ey;
  logic [49:0] bp_data;
  logic        bp_frame;
  logic        chk_valid;
  logic [15:0] chk_loc;
  logic [63:0] chk_thr;
  logic [11:0] chk_et, chk_ex, chk_ey;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] p_loc;
  logic [63:0] p_thr;
  logic [11:0] p_et, p_ex, p_ey;

  always #(CLK_PERIOD/2) clk = ~clk;

  roi_frame_packer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .scale_en(scale_en), .in_loc(in_loc), .in_thr(in_thr),
    .in_et(in_et), .in_ex(in_ex), .in_ey(in_ey),
    .bp_data(bp_data), .bp_frame(bp_frame), .chk_valid(chk_valid),
    .chk_loc(chk_loc), .chk_thr(chk_thr),
    .chk_et(chk_et), .chk_ex(chk_ex), .chk_ey(chk_ey)
  );

  task automatic chk(input string tag, input logic [199:0] act, input logic [199:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] field_of(input logic sc, input logic [11:0] v);
    return sc ? {4'h0, v[11:4]} : v;
  endfunction

  function automatic logic [199:0] build(input logic v, input logic sc,
      input logic [15:0] loc, input logic [63:0] thr,
      input logic [11:0] et, input logic [11:0] ex, input logic [11:0] ey);
    logic [199:0] s;
    logic [11:0]  f [3];
    int k;
    s = '0;
    k = 0;
    if (!v) return s;
    f[0] = field_of(sc, et);
    f[1] = field_of(sc, ex);
    f[2] = field_of(sc, ey);
    for (int i = 0; i < 8; i++) begin
      for (int b = 0; b < 2; b++) begin s[k] = loc[2*i+b]; k++; end
      for (int b = 0; b < 8; b++) begin s[k] = thr[8*i+b]; k++; end
    end
    for (int j = 0; j < 3; j++)
      for (int b = 0; b < 12; b++) begin s[k] = f[j][b]; k++; end
    return s;
  endfunction

  task automatic scramble();
    in_valid = 1'($urandom);
    scale_en = 1'($urandom);
    in_loc   = 16'($urandom);
    in_thr   = {$urandom, $urandom};
    in_et    = 12'($urandom);
    in_ex    = 12'($urandom);
    in_ey    = 12'($urandom);
  endtask

  task automatic crossing(input logic v, input logic sc,
      input logic [15:0] loc, input logic [63:0] thr,
      input logic [11:0] et, input logic [11:0] ex, input logic [11:0] ey);
    logic [199:0] exp;
    string base;
    chk("R3 ready at capture", 200'(in_ready), 200'(1'b1));
    in_valid = v; scale_en = sc; in_loc = loc; in_thr = thr;
    in_et = et; in_ex = ex; in_ey = ey;
    exp  = build(v, sc, loc, thr, et, ex, ey);
    base = !v ? "R4" : (sc ? "R8" : "R5/R6");
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      chk("R2 frame strobe", 200'(bp_frame), 200'(t == 0));
      chk(t == 3 ? "R7 slot3 zero" : {base, " slot data R9 R11"},
          200'(bp_data), 200'(exp[t*50 +: 50]));
      if (t == 2) chk("R7 slot2 pad", 200'(bp_data[49:16]), 200'(0));
      chk("R3 ready only last slot", 200'(in_ready), 200'(t == 3));
      if (t == 0) begin
        chk("R10 chk_valid", 200'(chk_valid), 200'(1'b1));
        chk("R10 chk_loc", 200'(chk_loc), 200'(p_loc));
        chk("R10 chk_thr", 200'(chk_thr), 200'(p_thr));
        chk("R10 chk sums", 200'({chk_et, chk_ex, chk_ey}), 200'({p_et, p_ex, p_ey}));
      end else begin
        chk("R10 chk_valid low", 200'(chk_valid), 200'(1'b0));
      end
      if (t < 3) scramble();
    end
    p_loc = v ? loc : '0;
    p_thr = v ? thr : '0;
    p_et  = v ? field_of(sc, et) : '0;
    p_ex  = v ? field_of(sc, ex) : '0;
    p_ey  = v ? field_of(sc, ey) : '0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = int'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    in_valid = 1'b0; scale_en = 1'b0;
    in_loc = '0; in_thr = '0; in_et = '0; in_ex = '0; in_ey = '0;
    p_loc = '0; p_thr = '0; p_et = '0; p_ex = '0; p_ey = '0;
    repeat (4) @(negedge clk);
    chk("R1 frame in reset", 200'(bp_frame), 200'(1'b1));
    chk("R1 data in reset", 200'(bp_data), 200'(0));
    rst_n = 1'b1;
    #1;
    chk("R1 frame after reset", 200'(bp_frame), 200'(1'b1));
    chk("R1 data after reset", 200'(bp_data), 200'(0));
    chk("R1 chk_valid after reset", 200'(chk_valid), 200'(1'b0));
    while (!in_ready) @(negedge clk);

    crossing(1'b1, 1'b0, 16'hFFFF, {64{1'b1}}, 12'hFFF, 12'hFFF, 12'hFFF);
    crossing(1'b1, 1'b1, 16'hFFFF, {64{1'b1}}, 12'hFFF, 12'hFFF, 12'hFFF);
    crossing(1'b1, 1'b1, 16'h0001, 64'h0, 12'h00F, 12'h010, 12'h7F0);
    crossing(1'b0, 1'b0, 16'hA5A5, 64'hDEAD_BEEF_0123_4567, 12'h123, 12'h456, 12'h789);
    crossing(1'b1, 1'b0, 16'h8000, 64'h8000_0000_0000_0001, 12'h001, 12'h800, 12'h555);
    crossing(1'b1, 1'b0, 16'h0003, 64'h0000_0000_0000_00FF, 12'h000, 12'h000, 12'hAAA);
    for (int n = 0; n < 300; n++) begin
      crossing(1'($urandom_range(0, 7) != 0), 1'($urandom), 16'($urandom),
               {$urandom, $urandom}, 12'($urandom), 12'($urandom), 12'($urandom));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule